// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Responder

This block gathers eight interrupt request lines, four per serial channel (channels A and B), and presents them to a CPU that uses vectored interrupts. Each request is captured into a pending flag. The active-low interrupt output is asserted while any enabled source is pending.

The CPU acknowledges an interrupt with a bus cycle in which the opcode-fetch strobe and the I/O strobe are both low and the memory strobe is high. At the first clock of that cycle the block picks the highest-priority enabled pending source and latches its vector. It then drives that vector, with a drive-enable, until the I/O strobe returns high. When the cycle ends, the served source's pending flag is cleared, so the next source can be taken on the following acknowledge.

A mask register, written through a simple write strobe, keeps individual sources out of both the interrupt output and the vector choice.

Top module: `irq_vector_responder`

## Requirements
- R1: After synchronous reset, int_n is high, vec_oe is low, vec_o is 0x00, no source is pending and all eight sources are enabled in the mask.
- R2: A request seen high on any clock edge sets that source's pending flag at that edge. int_n goes low right after that edge and stays low until the source is acknowledged, even if the request line has dropped.
- R3: Source i (req_i bit i) has vector 0x40 + 2*i. Bits 0..3 are channel B transmit-empty, status, receive and external. Bits 4..7 are the same four causes for channel A, giving 0x48, 0x4A, 0x4C and 0x4E.
- R4: An acknowledge is recognised only when m1_n = 0, iorq_n = 0 and mreq_n = 1. With mreq_n low, or with m1_n high, the bus is not driven and no pending flag is cleared.
- R5: vec_oe is high only from the clock edge that recognises an acknowledge until iorq_n goes high, and it falls as soon as iorq_n goes high. While vec_oe is low, vec_o reads 0x00.
- R6: Priority is fixed, from highest to lowest: A receive, B receive, A transmit-empty, B transmit-empty, A external, B external, A status, B status.
- R7: The vector is latched at the first clock of the acknowledge. It does not change while the cycle lasts, even if a higher-priority request arrives during it.
- R8: On the first clock edge after iorq_n returns high, the served source's pending flag is cleared. A request still held high sets the flag again on the next edge.
- R9: A zero bit in the mask (written on a clock edge where mask_we = 1) keeps that source out of int_n and out of the vector choice. The source still captures requests and becomes visible again when the bit is set back to one.
- R10: An acknowledge with no enabled pending source leaves vec_oe low for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 8 | Interrupt request lines, one per source |
| m1_n | input | 1 | CPU opcode-fetch strobe, active low |
| iorq_n | input | 1 | CPU I/O strobe, active low |
| mreq_n | input | 1 | CPU memory strobe, active low |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 8 | New enable mask, 1 = enabled |
| int_n | output | 1 | Interrupt request to the CPU, active low |
| vec_o | output | 8 | Vector byte for the data bus |
| vec_oe | output | 1 | Data-bus drive enable for vec_o |

## Verification
Each source is raised on its own and acknowledged, which maps every request bit to its table vector and its clear. All eight are then raised together and acknowledged eight times, so the order of the returned vectors exposes any swap in the priority ranking. Acknowledge-like strobe patterns with the memory strobe low or the fetch strobe high are mixed with real acknowledges to show that only the true cycle drives the bus. Further runs separate capture from clear: a higher request arriving during an acknowledge, a request held across the clear, masked sources competing with unmasked ones, and an acknowledge with nothing pending.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NUM_CHAN = 2;
    localparam int CAUSES   = 4;
    localparam int NUM_SRC  = NUM_CHAN * CAUSES;
    localparam int IDX_W    = $clog2(NUM_SRC);

    // cause position inside a channel group; the vector table depends on it
    typedef enum logic [1:0] {
        CAUSE_TXE  = 2'd0,
        CAUSE_STAT = 2'd1,
        CAUSE_RXF  = 2'd2,
        CAUSE_EXT  = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_HOLD = 2'd1,
        ACK_SPUR = 2'd2
    } ack_state_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // level 0 is the most urgent cause
    function automatic cause_e cause_at_level(input int lvl);
        case (lvl)
            0:       return CAUSE_RXF;
            1:       return CAUSE_TXE;
            2:       return CAUSE_EXT;
            default: return CAUSE_STAT;
        endcase
    endfunction

    // rank 0 is the highest priority; the upper channel group wins ties
    function automatic logic [IDX_W-1:0] src_at_rank(input int r);
        int grp;
        int cause;
        grp   = NUM_CHAN - 1 - (r % NUM_CHAN);
        cause = int'(cause_at_level(r / NUM_CHAN));
        return IDX_W'(grp * CAUSES + cause);
    endfunction

    function automatic logic [7:0] vec_of(input logic [7:0] base,
                                          input logic [7:0] stride,
                                          input logic [IDX_W-1:0] idx);
        logic [7:0] wide_idx;
        wide_idx = {{(8-IDX_W){1'b0}}, idx};
        return base + stride * wide_idx;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_vec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] clr,
    input  logic               en_we,
    input  logic [NUM_SRC-1:0] en_wdata,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] en
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend[gi] <= 1'b0;
                end else if (clr[gi]) begin
                    pend[gi] <= 1'b0;
                end else if (req[gi]) begin
                    pend[gi] <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '1;
        end else if (en_we) begin
            en <= en_wdata;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_vec_pkg::*;
(
    input  logic [NUM_SRC-1:0] cand,
    output pick_t              pick
);

    always_comb begin
        pick = '0;
        // walk from lowest to highest rank so the most urgent hit is kept
        for (int r = NUM_SRC - 1; r >= 0; r--) begin
            if (cand[src_at_rank(r)]) begin
                pick.valid = 1'b1;
                pick.idx   = src_at_rank(r);
            end
        end
    end

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_vec_pkg::*;
#(
    parameter logic [7:0] VEC_BASE   = 8'h40,
    parameter logic [7:0] VEC_STRIDE = 8'd2
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               m1_n,
    input  logic               iorq_n,
    input  logic               mreq_n,
    input  pick_t              pick,
    output logic [NUM_SRC-1:0] clr,
    output logic [7:0]         vec_o,
    output logic               vec_oe
);

    ack_state_e       state;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       vec_q;
    logic             ack_det;

    assign ack_det = !m1_n && !iorq_n && mreq_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ACK_IDLE;
            idx_q <= '0;
            vec_q <= '0;
        end else begin
            case (state)
                ACK_IDLE: begin
                    if (ack_det) begin
                        if (pick.valid) begin
                            state <= ACK_HOLD;
                            idx_q <= pick.idx;
                            vec_q <= vec_of(VEC_BASE, VEC_STRIDE, pick.idx);
                        end else begin
                            state <= ACK_SPUR;
                        end
                    end
                end
                ACK_HOLD: if (iorq_n) state <= ACK_IDLE;
                ACK_SPUR: if (iorq_n) state <= ACK_IDLE;
                default:  state <= ACK_IDLE;
            endcase
        end
    end

    always_comb begin
        clr = '0;
        if (state == ACK_HOLD && iorq_n) begin
            clr[idx_q] = 1'b1;
        end
    end

    assign vec_oe = (state == ACK_HOLD) && !iorq_n;
    assign vec_o  = vec_oe ? vec_q : 8'h00;

endmodule

// File: rtl/irq_vector_responder.sv
module irq_vector_responder
    import irq_vec_pkg::*;
#(
    parameter logic [7:0] VEC_BASE   = 8'h40,
    parameter logic [7:0] VEC_STRIDE = 8'd2
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [7:0]   req_i,
    input  logic         m1_n,
    input  logic         iorq_n,
    input  logic         mreq_n,
    input  logic         mask_we,
    input  logic [7:0]   mask_wdata,
    output logic         int_n,
    output logic [7:0]   vec_o,
    output logic         vec_oe
);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] cand;
    pick_t              pick;

    irq_pend_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .req      (req_i),
        .clr      (clr),
        .en_we    (mask_we),
        .en_wdata (mask_wdata),
        .pend     (pend),
        .en       (en)
    );

    assign cand  = pend & en;
    assign int_n = ~|cand;

    irq_prio_pick u_pick (
        .cand (cand),
        .pick (pick)
    );

    irq_ack_seq #(
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .m1_n   (m1_n),
        .iorq_n (iorq_n),
        .mreq_n (mreq_n),
        .pick   (pick),
        .clr    (clr),
        .vec_o  (vec_o),
        .vec_oe (vec_oe)
    );

endmodule

// File: rtl/irq_vector_responder_chk.sv
module irq_vector_responder_chk #(
    parameter logic [7:0] VEC_BASE   = 8'h40,
    parameter logic [7:0] VEC_STRIDE = 8'd2
)(
    input logic       clk,
    input logic       rst,
    input logic       iorq_n,
    input logic       int_n,
    input logic [7:0] vec_o,
    input logic       vec_oe
);

    localparam logic [7:0] VEC_TOP = 8'(VEC_BASE + VEC_STRIDE * 8'd7);

    AST_OE_NEEDS_IORQ: assert property (@(posedge clk) disable iff (rst)
        vec_oe |-> !iorq_n); // R5

    AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
        vec_oe |-> (vec_o >= VEC_BASE && vec_o <= VEC_TOP
                    && ((vec_o - VEC_BASE) % VEC_STRIDE) == 8'd0)); // R3

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
        (vec_oe && $past(vec_oe)) |-> $stable(vec_o)); // R7

    AST_DRIVE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_oe) |-> $past(!int_n)); // R10

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !vec_oe |-> (vec_o == 8'h00)); // R5

endmodule

bind irq_vector_responder irq_vector_responder_chk #(
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .iorq_n (iorq_n),
    .int_n  (int_n),
    .vec_o  (vec_o),
    .vec_oe (vec_oe)
);

// File: tb/irq_vector_responder_bench.sv
module irq_vector_responder_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = '0;
    logic       m1_n = 1'b1;
    logic       iorq_n = 1'b1;
    logic       mreq_n = 1'b1;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       int_n;
    logic [7:0] vec_o;
    logic       vec_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_responder u_irq_vector_responder (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_i),
        .m1_n       (m1_n),
        .iorq_n     (iorq_n),
        .mreq_n     (mreq_n),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .int_n      (int_n),
        .vec_o      (vec_o),
        .vec_oe     (vec_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [7:0] m);
        @(negedge clk) req_i = m;
        @(negedge clk) req_i = '0;
    endtask

    task automatic write_mask(input logic [7:0] m);
        @(negedge clk) begin mask_we = 1'b1; mask_wdata = m; end
        @(negedge clk) mask_we = 1'b0;
    endtask

    // one-clock acknowledge; returns at the negedge after the clearing edge
    task automatic ack(output logic [7:0] v, output logic oe_in, output logic oe_out);
        @(negedge clk) begin m1_n = 1'b0; iorq_n = 1'b0; end
        @(negedge clk);
        oe_in = vec_oe;
        v     = vec_o;
        m1_n = 1'b1; iorq_n = 1'b1;
        #1 oe_out = vec_oe;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 int_n", {7'b0, int_n}, 8'h01);
        check("R1 vec_oe", {7'b0, vec_oe}, 8'h00);
        check("R1 vec_o", vec_o, 8'h00);
    endtask

    task automatic t_table();
        logic [7:0] v; logic a; logic b;
        for (int i = 0; i < 8; i++) begin
            pulse_req(8'(1 << i));
            check("R2 int_n low after request", {7'b0, int_n}, 8'h00);
            ack(v, a, b);
            check("R3 vector", v, 8'(8'h40 + 2 * i));
            check("R5 drive during ack", {7'b0, a}, 8'h01);
            check("R5 release on iorq high", {7'b0, b}, 8'h00);
            check("R8 cleared after ack", {7'b0, int_n}, 8'h01);
        end
    endtask

    task automatic t_capture();
        logic [7:0] v; logic a; logic b;
        pulse_req(8'h20);
        repeat (3) @(negedge clk);
        check("R2 request captured", {7'b0, int_n}, 8'h00);
        ack(v, a, b);
        check("R3 A status vector", v, 8'h4A);
    endtask

    task automatic t_prio();
        logic [7:0] v; logic a; logic b;
        logic [7:0] exp_order [8] = '{8'h4C, 8'h44, 8'h48, 8'h40, 8'h4E, 8'h46, 8'h4A, 8'h42};
        pulse_req(8'hFF);
        for (int k = 0; k < 8; k++) begin
            ack(v, a, b);
            check("R6 priority order", v, exp_order[k]);
        end
        check("R6 all served", {7'b0, int_n}, 8'h01);
    endtask

    task automatic t_decode();
        logic [7:0] v; logic a; logic b;
        pulse_req(8'h40);
        @(negedge clk) begin m1_n = 1'b0; iorq_n = 1'b0; mreq_n = 1'b0; end
        @(negedge clk);
        check("R4 no drive with mreq_n low", {7'b0, vec_oe}, 8'h00);
        m1_n = 1'b1; iorq_n = 1'b1; mreq_n = 1'b1;
        @(negedge clk) iorq_n = 1'b0;
        @(negedge clk);
        check("R4 no drive in plain io cycle", {7'b0, vec_oe}, 8'h00);
        iorq_n = 1'b1;
        @(negedge clk);
        check("R4 pending kept", {7'b0, int_n}, 8'h00);
        ack(v, a, b);
        check("R4 A receive vector", v, 8'h4C);
    endtask

    task automatic t_hold();
        logic [7:0] v; logic a; logic b;
        pulse_req(8'h10);
        @(negedge clk) begin m1_n = 1'b0; iorq_n = 1'b0; end
        @(negedge clk);
        check("R7 latched vector", vec_o, 8'h48);
        req_i = 8'h40;
        @(negedge clk);
        req_i = 8'h00;
        check("R7 vector held", vec_o, 8'h48);
        @(negedge clk);
        check("R7 vector still held", vec_o, 8'h48);
        m1_n = 1'b1; iorq_n = 1'b1;
        @(negedge clk);
        ack(v, a, b);
        check("R7 late request served next", v, 8'h4C);
        check("R7 none left", {7'b0, int_n}, 8'h01);
    endtask

    task automatic t_repend();
        logic [7:0] v; logic a; logic b;
        @(negedge clk) req_i = 8'h04;
        ack(v, a, b);
        check("R8 vector", v, 8'h44);
        check("R8 clear wins on clearing edge", {7'b0, int_n}, 8'h01);
        @(negedge clk);
        check("R8 re-pended next edge", {7'b0, int_n}, 8'h00);
        req_i = 8'h00;
        ack(v, a, b);
        check("R8 final clear", {7'b0, int_n}, 8'h01);
    endtask

    task automatic t_mask();
        logic [7:0] v; logic a; logic b;
        write_mask(8'hBF);
        pulse_req(8'h40);
        check("R9 masked no int", {7'b0, int_n}, 8'h01);
        ack(v, a, b);
        check("R10 no drive without enabled pending", {7'b0, a}, 8'h00);
        pulse_req(8'h01);
        ack(v, a, b);
        check("R9 masked source skipped", v, 8'h40);
        write_mask(8'hFF);
        check("R9 unmasked pending visible", {7'b0, int_n}, 8'h00);
        ack(v, a, b);
        check("R9 A receive vector after unmask", v, 8'h4C);
    endtask

    task automatic t_spurious();
        logic [7:0] v; logic a; logic b;
        ack(v, a, b);
        check("R10 spurious ack no drive", {7'b0, a}, 8'h00);
        check("R10 spurious ack bus zero", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_table();
        t_capture();
        t_prio();
        t_decode();
        t_hold();
        t_repend();
        t_mask();
        t_spurious();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule